// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block is a clocked sequencer that carries single-word read and write requests from an on-chip requester to an external asynchronous static RAM with a 16-bit data bus and an 18-bit word address. The requester offers a request with a valid/ready handshake, carrying an address, write data, a two-bit lane mask and a direction flag. The controller drives the RAM's active-low select, write strobe, output enable and two lane strobes. It controls the shared data pins through a separate drive-enable. A read returns its word with a one-cycle valid pulse.

Every phase length is a whole number of clocks. Each one is derived when the design is built, from the clock period in nanoseconds and the RAM's timing figures: access, output-enable access, write-pulse, lane-pulse, address-to-end, data-setup, cycle and output-float times. Each count is the time divided by the clock period, rounded up, and never less than one. The controller keeps its own drivers off while the RAM may still be driving the bus, leaves an idle gap after every read, and does not move the address pins between accesses.

Top module: `asram_ctl`

## Requirements
- R1: During synchronous reset and in the first cycle after it, select, write strobe, output enable and both lane strobes are high. The drive-enable is low, ready is high and the response valid is low.
- R2: An accepted read holds select and output enable low and the write strobe high for RD cycles, where RD = ceil(max(read cycle, address access, output-enable access) / clock period).
- R3: Read data is sampled in the last of the RD cycles and presented with a response valid that is high for exactly one cycle. Bits 7:0 are forced to zero when mask bit 0 is 0, and bits 15:8 when mask bit 1 is 0.
- R4: After a read, the RAM stays deselected with output enable high for GAP = ceil(output-float time / clock period) cycles before ready returns.
- R5: An accepted write holds the write strobe low for PULSE = max(ceil(write pulse), ceil(lane pulse), ceil(address-to-end), HZ + SD) cycles. Output enable stays high for the whole write.
- R6: During a write, the drive-enable stays low for the first HZ = ceil(write-strobe float time) cycles of the strobe and is high for the remaining cycles, which number at least SD = ceil(data setup). The drive-enable is never high while output enable is low or the chip is deselected.
- R7: After the write strobe rises, select, lane strobes and drivers are held for HOLD = max(1, ceil(write cycle) - PULSE) cycles. Select then rises and the drivers turn off in the same cycle.
- R8: A request is taken only when valid and ready are both high. Ready stays low from acceptance until the end of the phase sequence: RD + GAP cycles for a read, PULSE + HOLD cycles for a write.
- R9: The address pins change only on the cycle after a request is accepted. They keep the last address while the controller is idle.
- R10: Mask bit 0 drives the low-lane strobe (data bits 7:0) and mask bit 1 drives the high-lane strobe (data bits 15:8), both inverted. A write with a lane disabled leaves that byte of the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 16 | Read data, disabled lanes zero |
| ram_addr | output | 18 | RAM address pins |
| ram_ce_n | output | 1 | RAM select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_hi_n | output | 1 | High-lane strobe, active low |
| ram_lo_n | output | 1 | Low-lane strobe, active low |
| ram_dq_o | output | 16 | Data toward the RAM |
| ram_dq_oe | output | 1 | Drive-enable for the data pins |
| ram_dq_i | input | 16 | Data from the RAM |

## Verification
A phase counter that is off by one shows up directly as a shorter or longer low period on select, output enable or the write strobe. It also moves the cycle in which ready comes back, so it is visible within the same transaction. A fault in the driver timing appears as drive-enable cycles that overlap a low output enable, or as too few driven cycles before the strobe rises, and the RAM model then stores wrong bytes. Lane-mask faults surface on the next read of that word as a changed or non-zero byte. A wrong capture point or response timing gives a stale word or a valid pulse in the wrong cycle.

// File: rtl/asram_pkg.sv
package asram_pkg;

  localparam int unsigned LANE_W = 8;
  localparam int unsigned LANES  = 2;
  localparam int unsigned DATA_W = LANE_W * LANES;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_GAP,
    PH_STROBE,
    PH_HOLD
  } phase_e;

  // Round a time up to whole clocks, at least one.
  function automatic int unsigned ns2cyc(input int unsigned t_ns, input int unsigned clk_ns);
    int unsigned c;
    c = (t_ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned read_cycles(input int unsigned clk_ns, input int unsigned t_rc,
                                              input int unsigned t_aa, input int unsigned t_doe);
    return ns2cyc(umax(t_rc, umax(t_aa, t_doe)), clk_ns);
  endfunction

  function automatic int unsigned strobe_cycles(input int unsigned clk_ns, input int unsigned t_pwe,
                                                input int unsigned t_bw, input int unsigned t_aw,
                                                input int unsigned t_hz, input int unsigned t_sd);
    int unsigned p;
    p = umax(ns2cyc(t_pwe, clk_ns), umax(ns2cyc(t_bw, clk_ns), ns2cyc(t_aw, clk_ns)));
    return umax(p, ns2cyc(t_hz, clk_ns) + ns2cyc(t_sd, clk_ns));
  endfunction

  function automatic int unsigned hold_cycles(input int unsigned clk_ns, input int unsigned t_wc,
                                              input int unsigned strobe);
    int unsigned wc;
    wc = ns2cyc(t_wc, clk_ns);
    return (wc > strobe + 1) ? (wc - strobe) : 1;
  endfunction

endpackage

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned RD_CYC    = 6,
  parameter int unsigned GAP_CYC   = 2,
  parameter int unsigned PULSE_CYC = 5,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned HZ_CYC    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  output logic              accept,
  output logic              rd_last,
  output logic [ADDR_W-1:0] addr,
  output logic              ce_n,
  output logic              we_n,
  output logic              oe_n,
  output logic [LANES-1:0]  be_n,
  output logic              dq_oe
);

  localparam logic [CNT_W-1:0] RD_END   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] STR_END  = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_END = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] HZ_L     = CNT_W'(HZ_CYC);

  phase_e           ph;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nx;
  logic             gap_last;
  logic             str_last;
  logic             hold_last;

  assign cnt_nx    = cnt + 1'b1;
  assign req_ready = (ph == PH_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_last   = (ph == PH_READ)   && (cnt == RD_END);
  assign gap_last  = (ph == PH_GAP)    && (cnt == GAP_END);
  assign str_last  = (ph == PH_STROBE) && (cnt == STR_END);
  assign hold_last = (ph == PH_HOLD)   && (cnt == HOLD_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      addr  <= '0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      be_n  <= '1;
      dq_oe <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (accept) begin
            addr  <= req_addr;
            ce_n  <= 1'b0;
            be_n  <= ~req_mask;
            cnt   <= '0;
            dq_oe <= 1'b0;
            if (req_we) begin
              ph   <= PH_STROBE;
              we_n <= 1'b0;
            end else begin
              ph   <= PH_READ;
              oe_n <= 1'b0;
            end
          end
        end
        PH_READ: begin
          if (rd_last) begin
            ce_n <= 1'b1;
            oe_n <= 1'b1;
            be_n <= '1;
            cnt  <= '0;
            ph   <= PH_GAP;
          end else begin
            cnt <= cnt_nx;
          end
        end
        PH_GAP: begin
          if (gap_last) begin
            cnt <= '0;
            ph  <= PH_IDLE;
          end else begin
            cnt <= cnt_nx;
          end
        end
        PH_STROBE: begin
          if (str_last) begin
            we_n  <= 1'b1;
            dq_oe <= 1'b1;
            cnt   <= '0;
            ph    <= PH_HOLD;
          end else begin
            cnt   <= cnt_nx;
            dq_oe <= (cnt_nx >= HZ_L);
          end
        end
        PH_HOLD: begin
          if (hold_last) begin
            ce_n  <= 1'b1;
            be_n  <= '1;
            dq_oe <= 1'b0;
            cnt   <= '0;
            ph    <= PH_IDLE;
          end else begin
            cnt <= cnt_nx;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // R2
  rd_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !oe_n |-> (we_n && !ce_n));

  // R4
  gap_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_GAP) |-> (ce_n && oe_n && be_n == '1));

  // R5
  wr_oe_chk: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n);

  // R6
  drv_contention_chk: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> (oe_n && !ce_n));

  // R7
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(we_n) |-> (dq_oe && !ce_n));

  // R8
  busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !ce_n |-> !req_ready);

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(addr));

endmodule

// File: rtl/asram_lanes.sv
module asram_lanes
  import asram_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              rd_last,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_valid
);

  logic [LANES-1:0]  mask_q;
  logic [DATA_W-1:0] capture;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign capture[g*LANE_W +: LANE_W] = dq_i[g*LANE_W +: LANE_W] & {LANE_W{mask_q[g]}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q    <= '0;
      dq_o      <= '0;
      rsp_data  <= '0;
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= rd_last;
      if (accept) begin
        mask_q <= req_mask;
        dq_o   <= req_wdata;
      end
      if (rd_last) begin
        rsp_data <= capture;
      end
    end
  end

  // R3
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  // R3
  rsp_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_last |=> rsp_valid);

endmodule

// File: rtl/asram_ctl.sv
module asram_ctl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned CLK_NS    = 10,
  parameter int unsigned T_RC_NS   = 55,
  parameter int unsigned T_AA_NS   = 55,
  parameter int unsigned T_DOE_NS  = 25,
  parameter int unsigned T_HZOE_NS = 20,
  parameter int unsigned T_WC_NS   = 55,
  parameter int unsigned T_PWE_NS  = 45,
  parameter int unsigned T_BW_NS   = 50,
  parameter int unsigned T_AW_NS   = 45,
  parameter int unsigned T_SD_NS   = 25,
  parameter int unsigned T_HZWE_NS = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic              ram_hi_n,
  output logic              ram_lo_n,
  output logic [15:0]       ram_dq_o,
  output logic              ram_dq_oe,
  input  logic [15:0]       ram_dq_i
);

  localparam int unsigned RD_CYC    = read_cycles(CLK_NS, T_RC_NS, T_AA_NS, T_DOE_NS);
  localparam int unsigned GAP_CYC   = ns2cyc(T_HZOE_NS, CLK_NS);
  localparam int unsigned HZ_CYC    = ns2cyc(T_HZWE_NS, CLK_NS);
  localparam int unsigned PULSE_CYC = strobe_cycles(CLK_NS, T_PWE_NS, T_BW_NS, T_AW_NS,
                                                    T_HZWE_NS, T_SD_NS);
  localparam int unsigned HOLD_CYC  = hold_cycles(CLK_NS, T_WC_NS, PULSE_CYC);
  localparam int unsigned MAX_CYC   = umax(umax(RD_CYC, GAP_CYC), umax(PULSE_CYC, HOLD_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  logic             accept;
  logic             rd_last;
  logic [LANES-1:0] be_n;

  asram_seq #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .RD_CYC   (RD_CYC),
    .GAP_CYC  (GAP_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HOLD_CYC (HOLD_CYC),
    .HZ_CYC   (HZ_CYC)
  ) seq_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_we   (req_we),
    .req_addr (req_addr),
    .req_mask (req_mask),
    .req_ready(req_ready),
    .accept   (accept),
    .rd_last  (rd_last),
    .addr     (ram_addr),
    .ce_n     (ram_ce_n),
    .we_n     (ram_we_n),
    .oe_n     (ram_oe_n),
    .be_n     (be_n),
    .dq_oe    (ram_dq_oe)
  );

  asram_lanes lanes_i (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .rd_last  (rd_last),
    .req_wdata(req_wdata),
    .req_mask (req_mask),
    .dq_i     (ram_dq_i),
    .dq_o     (ram_dq_o),
    .rsp_data (rsp_data),
    .rsp_valid(rsp_valid)
  );

  assign ram_lo_n = be_n[0];
  assign ram_hi_n = be_n[1];

endmodule

// File: tb/asram_ctl_tb.sv
module asram_ctl_tb_top;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_we = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic [17:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_oe_n, ram_hi_n, ram_lo_n, ram_dq_oe;
  logic [15:0] ram_dq_o;
  logic [15:0] ram_dq_i;

  int errors = 0;
  int checks = 0;
  int contention = 0;
  int wr_undriven = 0;
  bit armed = 1'b0;
  logic [15:0] mem_m [0:255];
  logic [15:0] shadow [0:255];

  always #(CLK_NS/2) clk = ~clk;

  asram_ctl #(.CLK_NS(CLK_NS)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_hi_n(ram_hi_n), .ram_lo_n(ram_lo_n), .ram_dq_o(ram_dq_o),
    .ram_dq_oe(ram_dq_oe), .ram_dq_i(ram_dq_i)
  );

  function automatic int cyc(int ns);
    int c = 1;
    while (c * CLK_NS < ns) c++;
    return c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [15:0] init_word(int i);
    return 16'(i * 263) ^ 16'h5A00;
  endfunction

  localparam int RD_E    = imax(cyc(55), cyc(25));
  localparam int GAP_E   = cyc(20);
  localparam int HZ_E    = cyc(20);
  localparam int SD_E    = cyc(25);
  localparam int PULSE_E = imax(imax(cyc(45), cyc(50)), imax(cyc(45), HZ_E + SD_E));
  localparam int HOLD_E  = (cyc(55) > PULSE_E + 1) ? cyc(55) - PULSE_E : 1;

  // RAM model: drives enabled lanes during a read, junk elsewhere
  always_comb begin
    ram_dq_i = 16'hBEEF;
    if (!ram_ce_n && !ram_oe_n && ram_we_n) begin
      ram_dq_i = 16'hEEEE;
      if (!ram_lo_n) ram_dq_i[7:0]  = mem_m[ram_addr[7:0]][7:0];
      if (!ram_hi_n) ram_dq_i[15:8] = mem_m[ram_addr[7:0]][15:8];
    end
  end

  // RAM model: stores on the rising write strobe
  initial begin
    for (int i = 0; i < 256; i++) mem_m[i] = init_word(i);
    forever begin
      @(posedge ram_we_n);
      if (armed && !ram_ce_n) begin
        if (!ram_dq_oe) wr_undriven++;
        if (!ram_lo_n) mem_m[ram_addr[7:0]][7:0]  = ram_dq_o[7:0];
        if (!ram_hi_n) mem_m[ram_addr[7:0]][15:8] = ram_dq_o[15:8];
      end
    end
  end

  always @(negedge clk) begin
    if (armed && ram_dq_oe && (!ram_oe_n || ram_ce_n)) contention++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic txn(input logic we, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int n = 0, ce_lo = 0, oe_lo = 0, we_lo = 0, drv = 0, drv_we = 0, rv_n = 0, rv_cnt = 0;
    int addr_moves = 0;
    logic [15:0] got = '0;
    logic [15:0] exp_rd;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_mask = m;
    @(posedge clk);
    n = 0;
    forever begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        req_valid = 1'b0;
        chk("R9 address presented", 32'(ram_addr), 32'(a));
        chk("R10 lane strobes", {30'd0, ram_hi_n, ram_lo_n}, {30'd0, ~m});
      end
      if (ram_addr !== a) addr_moves++;
      if (!ram_ce_n) ce_lo++;
      if (!ram_oe_n) oe_lo++;
      if (!ram_we_n) we_lo++;
      if (ram_dq_oe) drv++;
      if (ram_dq_oe && !ram_we_n) drv_we++;
      if (rsp_valid) begin rv_cnt++; if (rv_n == 0) begin rv_n = n; got = rsp_data; end end
      if (req_ready || n > 200) break;
    end
    chk("R9 address steady in cycle", 32'(addr_moves), 0);
    if (we) begin
      chk("R8 write ready latency", 32'(n), 32'(PULSE_E + HOLD_E + 1));
      chk("R5 write strobe cycles", 32'(we_lo), 32'(PULSE_E));
      chk("R5 output enable high in write", 32'(oe_lo), 0);
      chk("R7 select cycles in write", 32'(ce_lo), 32'(PULSE_E + HOLD_E));
      chk("R6 R7 driver cycles", 32'(drv), 32'(PULSE_E - HZ_E + HOLD_E));
      chk("R6 setup before strobe end", 32'(drv_we >= SD_E), 1);
      if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
    end else begin
      exp_rd = shadow[a[7:0]] & {{8{m[1]}}, {8{m[0]}}};
      chk("R8 read ready latency", 32'(n), 32'(RD_E + GAP_E + 1));
      chk("R2 output enable cycles", 32'(oe_lo), 32'(RD_E));
      chk("R4 select only during read", 32'(ce_lo), 32'(RD_E));
      chk("R3 valid position", 32'(rv_n), 32'(RD_E + 1));
      chk("R3 valid width", 32'(rv_cnt), 1);
      chk("R3 R10 read data", 32'(got), 32'(exp_rd));
      chk("R2 no write strobe in read", 32'(we_lo + drv), 0);
    end
  endtask

  task automatic idle_watch(input int k);
    logic [17:0] held = ram_addr;
    int moved = 0;
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (ram_addr !== held || !ram_ce_n) moved++;
    end
    chk("R9 address held while idle", 32'(moved), 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = init_word(i);
    repeat (3) @(negedge clk);
    chk("R1 strobes in reset", {27'd0, ram_ce_n, ram_we_n, ram_oe_n, ram_hi_n, ram_lo_n}, 32'h1F);
    rst = 1'b0;
    @(negedge clk);
    armed = 1'b1;
    chk("R1 strobes after reset", {27'd0, ram_ce_n, ram_we_n, ram_oe_n, ram_hi_n, ram_lo_n}, 32'h1F);
    chk("R1 drivers, ready, valid", {29'd0, ram_dq_oe, req_ready, rsp_valid}, 32'h2);

    // directed corners
    txn(1'b0, 18'h00010, 16'h0, 2'b11);
    txn(1'b1, 18'h00010, 16'h1234, 2'b11);
    txn(1'b0, 18'h00010, 16'h0, 2'b11);
    txn(1'b1, 18'h00010, 16'hABCD, 2'b01);   // R10 low lane only
    txn(1'b0, 18'h00010, 16'h0, 2'b11);
    txn(1'b1, 18'h00010, 16'h9F00, 2'b10);   // R10 high lane only
    txn(1'b1, 18'h3FF20, 16'hFFFF, 2'b00);   // R10 no lane enabled
    txn(1'b0, 18'h3FF20, 16'h0, 2'b11);
    txn(1'b0, 18'h00010, 16'h0, 2'b01);      // R3 high lane zeroed
    txn(1'b0, 18'h00010, 16'h0, 2'b10);      // R3 low lane zeroed
    idle_watch(7);

    void'($urandom(32'd4242));
    for (int t = 0; t < 120; t++) begin
      txn(1'($urandom % 2), 18'($urandom), 16'($urandom), 2'($urandom));
      if ($urandom % 4 == 0) idle_watch(1 + int'($urandom % 5));
    end

    chk("R6 no driver overlap with output enable", 32'(contention), 0);
    chk("R6 data driven at strobe end", 32'(wr_undriven), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL R8 watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end

endmodule